// File: doc/BRIEF.md
# Framed inversion-flag decoder with 1:2 demultiplexer

The block receives eleven serial data lanes and one frame lane, all sampled on a single bit-rate clock. A change of level on the frame lane marks the first bit of a 5-bit word on every data lane at once. Each lane has its own decoder. The decoder reads the leading bit of the word as an inversion flag and recovers a 4-bit nibble from the four bits that follow. It passes the nibble unchanged when the flag is 1 and complements it when the flag is 0.

Each decoded nibble is then spread over two output lanes during two output strobes. Serial lane n (0-based) drives output bit n, the lower group, and output bit n+11, the upper group. Both strobes fall inside the period of the next word, so output cycles run at two fifths of the bit rate.

The output is a valid-only stream. The serial side has no way to pause, so there is no ready and no back-pressure: the consumer must take the 22-bit word in every cycle where the strobe is high. Between strobes the output word keeps its last value.

Top module: `frame_nibble_demux`

## Requirements
- R1: After reset, and until the first frame transition has produced a complete word, `data_o` is all zeros and `valid_o` is 0. An asserted reset returns both to zero at once.
- R2: A frame transition is a frame level at a clock edge that differs from the level at the previous edge since reset. The bit sampled at that edge is bit 1 of a word. The first edge after reset only records the frame level.
- R3: Bit 1 of the word is the inversion flag, and bits 2 to 5 are nibble bits 1 to 4. A flag of 1 passes the nibble unchanged, and a flag of 0 complements all four bits.
- R4: Lanes decode independently. Serial lane n feeds `data_o[n]` (lower group) and `data_o[n+11]` (upper group).
- R5: In the first strobe of a nibble, the lower bit carries nibble bit 1 and the upper bit carries nibble bit 2. In the second strobe, the lower bit carries nibble bit 3 and the upper bit carries nibble bit 4.
- R6: Each completed word gives exactly two strobes, in consecutive cycles, followed by at least one cycle with `valid_o` low.
- R7: The first strobe is visible one clock after the edge that samples word bit 5, and the second strobe two clocks after it. This is within 3 output-strobe cycles.
- R8: A frame transition before bit 5 restarts the word at bit 1. The interrupted partial word produces no strobe.
- R9: Once aligned, if the expected frame transition does not arrive, word boundaries continue every 5 bits.
- R10: While `valid_o` is low, `data_o` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame lane; each level change marks a word start |
| lane_i | input | 11 | Serial data lanes, one bit per clock each |
| data_o | output | 22 | Bits [10:0] are the lower group, bits [21:11] the upper group |
| valid_o | output | 1 | One-cycle strobe per demultiplexer phase |

## Verification
The bound checker watches the strobe pattern on every cycle: a rising strobe is followed by a second strobe, and a pair of strobes is followed by a gap. It also checks that the output word stays put between strobes, and that nothing leaves the block before the frame lane has first changed level. The rest can only be shown by the bench's scenarios: the flag-driven complementing, the lane-to-output mapping, the bit order across the two phases, the exact latency, the restart on an early frame transition and the 5-bit cadence that continues when a transition is missing. The bench encodes table and pseudo-random nibbles and compares every strobe with values it computes itself.

// File: rtl/fdx_pkg.sv
package fdx_pkg;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned WORD_W = NIB_W + 1;
  localparam int unsigned PHASES = NIB_W / 2;

  typedef logic [NIB_W-1:0] nibble_t;

  // A set flag means the nibble travelled as-is; a clear flag means it was complemented.
  function automatic nibble_t undo_inversion(input logic flag, input nibble_t raw);
    return flag ? raw : ~raw;
  endfunction
endpackage

// File: rtl/fdx_frame_tracker.sv
module fdx_frame_tracker #(
  parameter int unsigned WORD_W = fdx_pkg::WORD_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  output logic word_done_o
);
  localparam int unsigned CW = $clog2(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic          prev_q;
  logic          have_prev_q;
  logic          aligned_q;
  logic [CW-1:0] idx_q;
  logic          start;

  // The sample at this edge is word bit 1 when the frame level moved.
  assign start = have_prev_q && (frame_i != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q      <= 1'b0;
      have_prev_q <= 1'b0;
      aligned_q   <= 1'b0;
      idx_q       <= '0;
    end else begin
      prev_q      <= frame_i;
      have_prev_q <= 1'b1;
      if (start) begin
        aligned_q <= 1'b1;
        idx_q     <= CW'(1);
      end else if (aligned_q) begin
        // Free-running cadence keeps word boundaries when a transition is missed.
        idx_q <= (idx_q == LAST) ? '0 : idx_q + CW'(1);
      end
    end
  end

  assign word_done_o = aligned_q && !start && (idx_q == LAST);
endmodule

// File: rtl/fdx_lane_decoder.sv
module fdx_lane_decoder
  import fdx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    bit_i,
  output nibble_t nib_o
);
  logic [NIB_W-1:0] sh_q;
  nibble_t          raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[NIB_W-2:0], bit_i};
  end

  // At the last-bit edge sh_q holds the flag and nibble bits 1..3; bit_i is bit 4.
  assign raw   = {sh_q[NIB_W-2:0], bit_i};
  assign nib_o = undo_inversion(sh_q[NIB_W-1], raw);
endmodule

// File: rtl/fdx_demux.sv
module fdx_demux
  import fdx_pkg::*;
#(
  parameter int unsigned LANES = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic [LANES-1:0][NIB_W-1:0] nib_i,
  output logic [2*LANES-1:0]          data_o,
  output logic                        valid_o
);
  localparam int unsigned PCW = $clog2(PHASES + 1);

  logic [LANES-1:0][NIB_W-1:0] hold_q;
  logic [LANES-1:0][NIB_W-1:0] src;
  logic [LANES-1:0][NIB_W-1:0] rest;
  logic [LANES-1:0]            lo_d;
  logic [LANES-1:0]            hi_d;
  logic [PCW-1:0]              left_q;
  logic                        emit;

  assign src  = load_i ? nib_i : hold_q;
  assign emit = load_i || (left_q != '0);

  // Every phase takes the top two bits and shifts the rest up.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lo_d[g] = src[g][NIB_W-1];
    assign hi_d[g] = src[g][NIB_W-2];
    assign rest[g] = src[g] << 2;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '0;
      left_q  <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= emit;
      if (emit) begin
        data_o <= {hi_d, lo_d};
        hold_q <= rest;
        left_q <= load_i ? PCW'(PHASES - 1) : left_q - PCW'(1);
      end
    end
  end
endmodule

// File: rtl/frame_nibble_demux.sv
module frame_nibble_demux
  import fdx_pkg::*;
#(
  parameter int unsigned LANES = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_i,
  input  logic [LANES-1:0]   lane_i,
  output logic [2*LANES-1:0] data_o,
  output logic               valid_o
);
  logic                        word_done;
  logic [LANES-1:0][NIB_W-1:0] nib;

  fdx_frame_tracker #(.WORD_W(WORD_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frame_i     (frame_i),
    .word_done_o (word_done)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_dec
    fdx_lane_decoder u_dec (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bit_i  (lane_i[g]),
      .nib_o  (nib[g])
    );
  end

  fdx_demux #(.LANES(LANES)) u_demux (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (word_done),
    .nib_i   (nib),
    .data_o  (data_o),
    .valid_o (valid_o)
  );
endmodule

// File: rtl/frame_nibble_demux_chk.sv
module frame_nibble_demux_chk #(
  parameter int unsigned LANES = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               frame_i,
  input logic [2*LANES-1:0] data_o,
  input logic               valid_o
);
  logic f_prev_q, f_have_q, seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_prev_q <= 1'b0;
      f_have_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      f_prev_q <= frame_i;
      f_have_q <= 1'b1;
      if (f_have_q && (frame_i != f_prev_q)) seen_q <= 1'b1;
    end
  end

  p_quiet_until_frame_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!valid_o && data_o == '0));

  p_second_phase_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |=> valid_o);

  p_gap_after_pair_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |=> !valid_o);

  p_hold_when_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

bind frame_nibble_demux frame_nibble_demux_chk #(.LANES(LANES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .frame_i (frame_i),
  .data_o  (data_o),
  .valid_o (valid_o)
);

// File: tb/test_frame_nibble_demux.sv
`timescale 1ns/1ps
module test_frame_nibble_demux;
  localparam int unsigned LANES = 11;
  localparam int unsigned OW    = 2 * LANES;

  // Stimulus table: {inversion flags per lane, nibble per lane (lane n at [4n+3:4n], bit 1 at 4n+3)}.
  localparam logic [54:0] VEC [0:7] = '{
    {11'h7FF, 44'h0123456789A},
    {11'h000, 44'hFEDCBA98765},
    {11'h555, 44'hF0F0F0F0F0F},
    {11'h2AA, 44'h00000000000},
    {11'h001, 44'hFFFFFFFFFFF},
    {11'h400, 44'h5A5A5A5A5A5},
    {11'h3C3, 44'h13579BDF024},
    {11'h0F0, 44'hC3C3C3C3C3C}
  };

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             frame_i = 1'b0;
  logic [LANES-1:0] lane_i = '0;
  logic [OW-1:0]    data_o;
  logic             valid_o;

  frame_nibble_demux #(.LANES(LANES)) i_frame_nibble_demux (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .frame_i (frame_i),
    .lane_i  (lane_i),
    .data_o  (data_o),
    .valid_o (valid_o)
  );

  always #4 clk = ~clk;

  int            total = 0;
  int            bad = 0;
  int            cyc = 0;
  bit            fl = 1'b0;
  bit            finished = 1'b0;
  string         ctx = "";
  logic [OW-1:0] exp_d [int];
  string         exp_t [int];
  logic [OW-1:0] last_d = '0;

  function automatic logic [OW-1:0] phase_word(input logic [LANES-1:0] flags,
                                               input logic [4*LANES-1:0] raw, input int ph);
    logic [OW-1:0] r;
    logic [3:0]    d;
    logic [3:0]    s;
    r = '0;
    for (int n = 0; n < LANES; n++) begin
      d = raw[n*4 +: 4];
      if (!flags[n]) d = ~d;
      s = d << (2 * ph);
      r[n]         = s[3];
      r[n + LANES] = s[2];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [OW-1:0] got, input logic [OW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got=%h exp=%h", ctx, tag, got, expv);
    end
  endtask

  // One bit time: check the outputs for this cycle, then drive the next sample.
  task automatic tick(input logic fr, input logic [LANES-1:0] ln);
    @(negedge clk);
    cyc++;
    if (exp_d.exists(cyc)) begin
      chk(valid_o === 1'b1, "R6 R7 strobe", OW'(valid_o), OW'(1));
      chk(data_o === exp_d[cyc], exp_t[cyc], data_o, exp_d[cyc]);
      last_d = exp_d[cyc];
    end else begin
      chk(valid_o === 1'b0, "R6 no strobe", OW'(valid_o), OW'(0));
      chk(data_o === last_d, "R1 R10 hold", data_o, last_d);
    end
    frame_i = fr;
    lane_i  = ln;
  endtask

  task automatic send_word(input logic [LANES-1:0] flags, input logic [4*LANES-1:0] raw, input bit toggle);
    for (int b = 0; b < 5; b++) begin
      logic [LANES-1:0] ln;
      for (int n = 0; n < LANES; n++) ln[n] = (b == 0) ? flags[n] : raw[n*4 + 4 - b];
      if (b == 0 && toggle) fl = ~fl;
      tick(fl, ln);
    end
    exp_d[cyc + 1] = phase_word(flags, raw, 0);
    exp_t[cyc + 1] = "R3 R4 R5 phase1";
    exp_d[cyc + 2] = phase_word(flags, raw, 1);
    exp_t[cyc + 2] = "R3 R4 R5 phase2";
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(fl, LANES'($urandom));
  endtask

  task automatic partial(input int nbits);
    fl = ~fl;
    for (int i = 0; i < nbits; i++) tick(fl, LANES'($urandom));
  endtask

  task automatic do_reset(input bit frame_level);
    rst_ni = 1'b0;
    exp_d.delete();
    exp_t.delete();
    last_d = '0;
    fl = frame_level;
    tick(fl, '0);
    tick(fl, '0);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=timeout exp=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state and quiet outputs while the frame lane is constant.
    ctx = "R1 reset";
    do_reset(1'b0);
    ctx = "R1 R2 pre-frame";
    idle(7);

    // R2: first word after reset starts at the first frame transition.
    ctx = "R2 first word";
    send_word(VEC[0][54:44], VEC[0][43:0], 1'b1);

    ctx = "R3 R4 R5 table";
    for (int i = 0; i < 8; i++) send_word(VEC[i][54:44], VEC[i][43:0], 1'b1);

    ctx = "R3 R4 R7 random";
    for (int i = 0; i < 40; i++)
      send_word(LANES'($urandom), {$urandom, 12'($urandom)}, 1'b1);

    // R9: no frame transition, cadence continues.
    ctx = "R9 flywheel";
    for (int i = 0; i < 3; i++)
      send_word(LANES'($urandom), {$urandom, 12'($urandom)}, 1'b0);
    send_word(VEC[6][54:44], VEC[6][43:0], 1'b1);

    // R8: early transition restarts the word; partials give no strobes.
    ctx = "R8 restart";
    partial(1);
    send_word(VEC[2][54:44], VEC[2][43:0], 1'b1);
    partial(4);
    send_word(VEC[5][54:44], VEC[5][43:0], 1'b1);
    partial(2);
    send_word(VEC[1][54:44], VEC[1][43:0], 1'b1);
    idle(4);

    // R1: reset while a strobe is pending clears the outputs at once.
    send_word(VEC[4][54:44], VEC[4][43:0], 1'b1);
    ctx = "R1 mid-stream reset";
    do_reset(1'b1);

    // R2: frame high out of reset is not a transition.
    ctx = "R2 frame high after reset";
    idle(9);
    send_word(VEC[7][54:44], VEC[7][43:0], 1'b1);
    send_word(VEC[3][54:44], VEC[3][43:0], 1'b1);
    idle(5);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule